// File: doc/BRIEF.md
# Alarm-Capable Real-Time Clock Counter

This block is a memory-mapped real-time clock. A slow reference clock (nominally 32.768 kHz) enters as a plain signal, passes a two-flop synchronizer into the bus clock domain, and its rising edges feed a programmable prescaler. Every 2×(DIV+1) slow edges the prescaler emits one tick. Each tick advances a 32-bit free-running counter. The low four counter bits count sixteenths of a second and bits [31:4] count whole seconds. When the counter passes 0xFFFFFFFF it returns to 0, and no carry out of the counter is kept.

Two compare registers raise alarm event flags when the counter steps onto their value. One status word holds those flags, a per-tick flag, and an enable bit for each of the three. Flags are cleared by writing 1 to them. A registered interrupt output combines each flag with its own enable. A scratch register is left alone by the synchronous reset, so software can keep its overflow epoch there across a soft reset. The counter runs only while the clock-select register holds the value 3.

Top module: `rtc_alarm_counter`

## Requirements
- R1: After reset, the counter, both compare registers, the status word and the clock select read 0, and the divider reads 1023.
- R2: The byte offsets are: counter 0x00, compare 0 at 0x04, status 0x08, divider 0x0C, compare 1 at 0x18, clock select 0x1C, scratch 0x40. A read returns, one clock later, the value the addressed register held at the preceding edge. An unmapped offset reads 0.
- R3: The prescaler and the counter advance only while the clock select holds 3. Any other value freezes both.
- R4: The slow clock passes through two synchronizer flops. A tick occurs on every 2×(DIV+1)-th synchronized rising edge.
- R5: Each tick adds 1 to the counter, and 0xFFFFFFFF steps to 0.
- R6: A counter write loads the written value and restarts the prescaler from zero. A tick falling in the same cycle is dropped.
- R7: The status bits are laid out as follows. Bit 0 is the compare-0 flag, bit 1 the tick flag, bit 2 the compare-0 enable, bit 3 the tick enable, bit 4 the compare-1 flag and bit 6 the compare-1 enable. The other bits read 0. A status write loads the three enable bits from the written data.
- R8: A compare flag is set only when its enable was 1 and a tick moves the counter onto that compare value.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: The tick flag is set on every tick, whether or not its enable is set.
- R11: The interrupt output is registered. It is the OR over the three pairs of a flag ANDed with its enable, and it follows the flags one cycle later.
- R12: The scratch register holds any 32-bit value written to it and keeps that value through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset (scratch excluded) |
| slow_clk_i | input | 1 | Asynchronous slow reference clock, sampled as data |
| bus_addr | input | 7 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The hardest situations to reach are those where a bus write and a tick fall in the same bus cycle: a flag clear racing a new event, a counter load racing a tick, or a compare value written just as the counter reaches it. Tick timing depends on the phase of the slow clock against the synchronizer, so a directed test alone cannot place these collisions. The bench therefore runs a behavioural reference model alongside the design on every clock and compares read data and the interrupt each cycle. Directed sequences then steer the counter near compare values and near wraparound, while W1C writes and counter loads are issued at several phases of the tick period.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFS_COUNT   = 'h00;
  localparam int OFS_CMP0    = 'h04;
  localparam int OFS_STATUS  = 'h08;
  localparam int OFS_DIVIDER = 'h0C;
  localparam int OFS_CMP1    = 'h18;
  localparam int OFS_CLKSEL  = 'h1C;
  localparam int OFS_SCRATCH = 'h40;

  localparam int ST_CMP0_FLAG = 0;
  localparam int ST_TICK_FLAG = 1;
  localparam int ST_CMP0_EN   = 2;
  localparam int ST_TICK_EN   = 3;
  localparam int ST_CMP1_FLAG = 4;
  localparam int ST_CMP1_EN   = 6;
  localparam int ST_W         = 7;

  localparam logic [1:0] CLKSEL_RUN = 2'd3;

  typedef struct packed {
    logic cmp1_en;
    logic cmp1_flag;
    logic tick_en;
    logic tick_flag;
    logic cmp0_en;
    logic cmp0_flag;
  } rtc_status_t;
endpackage

// File: rtl/rtc_sync_rise.sv
module rtc_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], async_i};
  end

  assign rise_o = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             edge_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = DIV_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  assign limit  = {div_i, 1'b1};
  assign tick_o = run_i && edge_i && !clear_i && (pre_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clear_i) pre_q <= '0;
    else if (run_i && edge_i) begin
      if (pre_q == limit) pre_q <= '0;
      else                pre_q <= pre_q + PRE_W'(1);
    end
  end

  // R4: after a tick the prescaler restarts its period
  a_r4_restart_after_tick: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (pre_q == '0));
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [ST_W-1:0] wdata_i,
  input  logic            tick_i,
  input  logic            hit0_i,
  input  logic            hit1_i,
  output rtc_status_t     st_o,
  output logic            irq_o
);
  rtc_status_t st_q;
  logic set0, set1;

  assign set0 = hit0_i & st_q.cmp0_en;
  assign set1 = hit1_i & st_q.cmp1_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_i) begin
        st_q.cmp0_en <= wdata_i[ST_CMP0_EN];
        st_q.tick_en <= wdata_i[ST_TICK_EN];
        st_q.cmp1_en <= wdata_i[ST_CMP1_EN];
      end
      st_q.cmp0_flag <= set0   | (st_q.cmp0_flag & ~(wr_i & wdata_i[ST_CMP0_FLAG]));
      st_q.tick_flag <= tick_i | (st_q.tick_flag & ~(wr_i & wdata_i[ST_TICK_FLAG]));
      st_q.cmp1_flag <= set1   | (st_q.cmp1_flag & ~(wr_i & wdata_i[ST_CMP1_FLAG]));
      irq_o <= (st_q.cmp0_flag & st_q.cmp0_en) | (st_q.tick_flag & st_q.tick_en) |
               (st_q.cmp1_flag & st_q.cmp1_en);
    end
  end

  assign st_o = st_q;

  // R8: a compare flag only rises while its enable was set
  a_r8_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q.cmp0_flag) |-> $past(st_q.cmp0_en));
  a_r8_flag1_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q.cmp1_flag) |-> $past(st_q.cmp1_en));
  // R9: a write of 1 clears the flag when no new event arrives
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_i && wdata_i[ST_CMP0_FLAG] && !set0) |=> !st_q.cmp0_flag);
endmodule

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter
  import rtc_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 16,
  parameter int DIV_RST     = 1023,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, cmp0_q, cmp1_q, scratch_q;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        clksel_q;
  logic              slow_rise, tick, clk_on;
  logic              wr_cnt, wr_st;
  logic [DATA_W-1:0] cnt_inc;
  rtc_status_t       st;

  assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_st   = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
  assign clk_on  = (clksel_q == CLKSEL_RUN);
  assign cnt_inc = cnt_q + DATA_W'(1);

  rtc_sync_rise #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_i(slow_clk_i), .rise_o(slow_rise));

  rtc_prescaler #(.DIV_W(DIV_W)) pre_i (
    .clk(clk), .rst(rst), .run_i(clk_on), .edge_i(slow_rise),
    .clear_i(wr_cnt), .div_i(div_q), .tick_o(tick));

  rtc_status_flags stat_i (
    .clk(clk), .rst(rst), .wr_i(wr_st), .wdata_i(bus_wdata[ST_W-1:0]),
    .tick_i(tick), .hit0_i(tick && (cnt_inc == cmp0_q)),
    .hit1_i(tick && (cnt_inc == cmp1_q)), .st_o(st), .irq_o(irq_o));

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (tick)   cnt_q <= cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp0_q   <= '0;
      cmp1_q   <= '0;
      div_q    <= DIV_W'(DIV_RST);
      clksel_q <= '0;
    end else if (bus_we) begin
      case (int'(bus_addr))
        OFS_CMP0:    cmp0_q   <= bus_wdata;
        OFS_CMP1:    cmp1_q   <= bus_wdata;
        OFS_DIVIDER: div_q    <= bus_wdata[DIV_W-1:0];
        OFS_CLKSEL:  clksel_q <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  // Scratch is deliberately outside the reset so its contents survive it
  always_ff @(posedge clk) begin
    if (bus_we && (bus_addr == ADDR_W'(OFS_SCRATCH))) scratch_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (int'(bus_addr))
        OFS_COUNT:   bus_rdata <= cnt_q;
        OFS_CMP0:    bus_rdata <= cmp0_q;
        OFS_STATUS:  bus_rdata <= DATA_W'({st.cmp1_en, 1'b0, st.cmp1_flag, st.tick_en,
                                           st.cmp0_en, st.tick_flag, st.cmp0_flag});
        OFS_DIVIDER: bus_rdata <= DATA_W'(div_q);
        OFS_CMP1:    bus_rdata <= cmp1_q;
        OFS_CLKSEL:  bus_rdata <= DATA_W'(clksel_q);
        OFS_SCRATCH: bus_rdata <= scratch_q;
        default:     bus_rdata <= '0;
      endcase
    end
  end

  // R5: a tick steps the counter by exactly one (modulo 2^32)
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    ($past(tick) && !$past(rst)) |-> (cnt_q == $past(cnt_q) + DATA_W'(1)));
  // R3: with the clock deselected and no load, the counter holds
  a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clk_on) && !$past(wr_cnt)) |-> $stable(cnt_q));
endmodule

// File: tb/rtc_alarm_counter_tb_top.sv
module rtc_alarm_counter_tb_top;
  localparam int SLOW_HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_alarm_counter dut_i (
    .clk(clk), .rst(rst), .slow_clk_i(slow), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .bus_rdata(rdata), .irq_o(irq));

  int slow_cnt = 0;
  always @(negedge clk) begin
    slow_cnt++;
    if (slow_cnt == SLOW_HALF) begin slow_cnt = 0; slow = ~slow; end
  end

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt, m_al0, m_al1, m_div, m_scr, m_rdata;
  logic [1:0]  m_sel;
  bit m_a0f, m_tkf, m_a1f, m_a0e, m_tke, m_a1e, m_irq, m_rvalid, m_scr_known, m_init;
  int m_pre;
  bit m_hist[$];

  function automatic logic [31:0] m_read(logic [6:0] a);
    case (a)
      7'h00: return m_cnt;
      7'h04: return m_al0;
      7'h08: return {25'b0, m_a1e, 1'b0, m_a1f, m_tke, m_a0e, m_tkf, m_a0f};
      7'h0C: return m_div;
      7'h18: return m_al1;
      7'h1C: return {30'b0, m_sel};
      7'h40: return m_scr;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit rise, tk, s0, s1;
    if (rst) begin
      m_cnt = 0; m_al0 = 0; m_al1 = 0; m_div = 1023; m_sel = 0; m_pre = 0;
      {m_a0f, m_tkf, m_a1f, m_a0e, m_tke, m_a1e, m_irq} = '0;
      m_rdata = 0; m_rvalid = 1; m_init = 1;
      m_hist = '{0, 0, 0};
    end else begin
      m_rvalid = !(addr == 7'h40 && !m_scr_known);
      m_rdata  = m_read(addr);
      m_irq    = (m_a0f && m_a0e) || (m_tkf && m_tke) || (m_a1f && m_a1e);
      rise = m_hist[1] && !m_hist[0];
      tk = 0;
      if (we && addr == 7'h00) begin m_cnt = wdata; m_pre = 0; end
      else if (m_sel == 2'd3 && rise) begin
        if (m_pre == 2 * int'(m_div) + 1) begin m_pre = 0; tk = 1; end
        else m_pre++;
      end
      s0 = 0; s1 = 0;
      if (tk) begin
        m_cnt = m_cnt + 1;
        s0 = m_a0e && (m_cnt == m_al0);
        s1 = m_a1e && (m_cnt == m_al1);
      end
      if (we && addr == 7'h08) begin
        if (wdata[0]) m_a0f = 0;
        if (wdata[1]) m_tkf = 0;
        if (wdata[4]) m_a1f = 0;
        m_a0e = wdata[2]; m_tke = wdata[3]; m_a1e = wdata[6];
      end
      if (s0) m_a0f = 1;
      if (tk) m_tkf = 1;
      if (s1) m_a1f = 1;
      if (we) case (addr)
        7'h04: m_al0 = wdata;
        7'h18: m_al1 = wdata;
        7'h0C: m_div = {16'b0, wdata[15:0]};
        7'h1C: m_sel = wdata[1:0];
        default: ;
      endcase
      m_hist.push_back(m_hist[2]);
      m_hist.delete(0);
      m_hist[2] = slow;
    end
    if (we && addr == 7'h40) begin m_scr = wdata; m_scr_known = 1; end
  end

  // R11/R2 per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_init && !rst && !done) begin
      compared++;
      if (irq !== m_irq) begin
        mismatched++;
        $display("FAIL R11 cycle %0d irq actual=%0b expected=%0b", cyc, irq, m_irq);
      end
      if (m_rvalid) begin
        compared++;
        if (rdata !== m_rdata) begin
          mismatched++;
          $display("FAIL R2 cycle %0d rdata actual=%08h expected=%08h", cyc, rdata, m_rdata);
        end
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_bit(input logic [6:0] a, input int b, output bit seen);
    logic [31:0] v;
    seen = 0;
    for (int i = 0; i < 600 && !seen; i++) begin
      rd(a, v);
      seen = v[b];
    end
  endtask

  task automatic measure_period(input int exp, input string req);
    int t0, t1;
    logic [31:0] last;
    int seen;
    @(negedge clk); addr = 7'h00;
    @(negedge clk); last = rdata; seen = 0; t0 = 0; t1 = 0;
    for (int i = 0; i < 600 && seen < 2; i++) begin
      @(negedge clk);
      if (rdata != last) begin
        if (seen == 0) t0 = cyc; else t1 = cyc;
        seen++; last = rdata;
      end
    end
    chk(seen == 2 && (t1 - t0) == exp, req, t1 - t0, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    bit seen;
    idle(4);
    rst = 1'b0;
    // R1 reset values
    rd(7'h00, v); chk(v == 0, "R1 counter reset", v, 0);
    rd(7'h08, v); chk(v == 0, "R1 status reset", v, 0);
    rd(7'h0C, v); chk(v == 1023, "R1 divider reset", v, 1023);
    rd(7'h1C, v); chk(v == 0, "R1 clock select reset", v, 0);
    rd(7'h18, v); chk(v == 0, "R1 compare1 reset", v, 0);
    // R2 map and unmapped
    wr(7'h04, 32'h1234_5678); rd(7'h04, v); chk(v == 32'h1234_5678, "R2 compare0 readback", v, 32'h1234_5678);
    rd(7'h10, v); chk(v == 0, "R2 unmapped read", v, 0);
    // R3 frozen while clock select != 3
    wr(7'h0C, 32'd1);
    idle(120); rd(7'h00, v); chk(v == 0, "R3 frozen with select 0", v, 0);
    wr(7'h1C, 32'd3);
    // R4 period with DIV=1 and DIV=2
    measure_period(2 * 2 * 2 * SLOW_HALF, "R4 period DIV=1");
    wr(7'h0C, 32'd2);
    measure_period(2 * 3 * 2 * SLOW_HALF, "R4 period DIV=2");
    wr(7'h0C, 32'd1);
    // R3 other select value freezes
    wr(7'h1C, 32'd2); rd(7'h00, c); idle(150); rd(7'h00, v);
    chk(v == c, "R3 frozen with select 2", v, c);
    wr(7'h1C, 32'd3);
    // R6 load
    wr(7'h00, 32'h0000_0100); rd(7'h00, v); chk(v == 32'h100, "R6 counter load", v, 32'h100);
    // R8/R9/R11 compare 0
    rd(7'h00, c); wr(7'h04, c + 3); wr(7'h08, 32'h4);
    poll_bit(7'h08, 0, seen); chk(seen, "R8 compare0 flag set", seen, 1);
    rd(7'h00, v); chk(v == c + 3, "R8 counter at compare0", v, c + 3);
    chk(irq == 1'b1, "R11 irq from compare0", irq, 1);
    wr(7'h08, 32'h4); rd(7'h08, v); chk(v[0] == 1'b1, "R9 write 0 keeps flag", v[0], 1);
    wr(7'h08, 32'h5); rd(7'h08, v);
    chk(v[0] == 1'b0 && v[2] == 1'b1, "R9 write 1 clears flag, R7 enable kept", v, 32'h4);
    idle(1); chk(irq == 1'b0, "R11 irq drops after clear", irq, 0);
    // R8 disabled compare never flags
    wr(7'h08, 32'h13); rd(7'h00, c); wr(7'h04, c + 2);
    idle(200); rd(7'h08, v); chk(v[0] == 1'b0, "R8 disabled compare0 no flag", v[0], 0);
    // R10/R11 tick flag
    wr(7'h08, 32'h13); idle(40); rd(7'h08, v);
    chk(v[1] == 1'b1, "R10 tick flag without enable", v[1], 1);
    chk(irq == 1'b0, "R11 tick masked", irq, 0);
    wr(7'h08, 32'h8); idle(1); chk(irq == 1'b1, "R11 tick enabled irq", irq, 1);
    wr(7'h08, 32'h0); idle(1); chk(irq == 1'b0, "R11 tick disabled irq", irq, 0);
    // R7/R8 compare 1 at bits 4 and 6
    wr(7'h08, 32'h13); rd(7'h00, c); wr(7'h18, c + 2); wr(7'h08, 32'h40);
    poll_bit(7'h08, 4, seen); chk(seen, "R7 compare1 flag at bit 4", seen, 1);
    chk(irq == 1'b1, "R11 irq from compare1", irq, 1);
    wr(7'h08, 32'h50); rd(7'h08, v); chk(v[4] == 1'b0, "R9 compare1 clear", v[4], 0);
    // R5 wraparound
    wr(7'h08, 32'h13);
    wr(7'h00, 32'hFFFF_FFFF);
    v = 32'hFFFF_FFFF;
    for (int i = 0; i < 200 && v == 32'hFFFF_FFFF; i++) rd(7'h00, v);
    chk(v == 0, "R5 wrap to zero", v, 0);
    // R12 scratch survives reset
    wr(7'h40, 32'hA5A5_1234);
    @(negedge clk); rst = 1'b1; idle(3); rst = 1'b0;
    rd(7'h40, v); chk(v == 32'hA5A5_1234, "R12 scratch kept", v, 32'hA5A5_1234);
    rd(7'h0C, v); chk(v == 1023, "R1 divider after soft reset", v, 1023);
    idle(5);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule